// File: doc/BRIEF.md
# AC-link reset and wake sequencer

This block handles power management for the controller side of an AC'97-style serial audio link. It runs entirely on the always-running system clock, because the codec bit clock is stopped while the link sleeps. It watches the codec serial data input for a wake edge, latches a wake flag, and raises an interrupt if the mask allows. On a software request it produces one of two reset pulses: a warm reset, which holds the frame sync output high for a fixed number of system clocks while the bit clock is absent, or a cold reset, which pulls the active-low codec reset line low for a programmable number of system clocks.

After either pulse the block waits until it has seen a set number of rising bit-clock edges. Only then does it report the link ready. Sleep is entered when the slot assembler reports an outgoing codec register write to the power-down register at address 0x26 with its deep power-down bit set.

Software reaches the block through four 8-bit registers: mode, mask, status and cold-pulse length. Clearing the enable bit resets the controller logic and leaves the mask and length registers untouched.

Top module: `aclink_pwr_seq`

## Requirements
- R1: After rst_n is released, link_sync_out is 0, link_rst_n is 1, irq is 0, and the mode register (address 0) and the status register (address 2) both read 0.
- R2: While the asleep flag (status bit 3) is set, a rising edge on link_sdata_in sets the wake flag (status bit 1) within 4 clocks. A rising edge while not asleep leaves the wake flag at 0.
- R3: Writing 1 to status bit 1 clears the wake flag. A data input that stays high afterwards does not set the flag again.
- R4: irq equals the wake flag ANDed with mask register (address 1) bit 0.
- R5: A power-down report (pd_wr_valid with pd_wr_addr = 0x26 and pd_wr_pr4 = 1) sets the asleep flag, provided the block is enabled. A report with a different address, or with pd_wr_pr4 = 0, has no effect. Starting a reset sequence clears the asleep flag.
- R6: Writing mode bit 1 (with enable bit 0 set) while idle starts a warm reset. link_sync_out goes high from the clock edge that takes the write and stays high for exactly WARM_CYCLES clocks. link_rst_n stays high throughout.
- R7: Writing mode bit 2 while idle starts a cold reset. link_rst_n goes low for the number of clocks held in the length register (address 3), with a value of 0 treated as 1. link_sync_out stays low.
- R8: From the start of a reset sequence, busy (status bit 2) is set and ready (status bit 0) is clear. After the pulse ends, the block counts rising link_bitclk edges. Once BCLK_EDGES edges have arrived, ready is set and busy is cleared.
- R9: Reset requests made while busy are ignored. If warm and cold are requested in the same write, cold wins.
- R10: Clearing mode bit 0 aborts any running sequence. It releases both link outputs and clears ready, busy, wake and asleep. Reset requests are ignored while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, always running |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| pd_wr_valid | input | 1 | Slot assembler is sending a codec register write |
| pd_wr_addr | input | 7 | Codec register address of that write |
| pd_wr_pr4 | input | 1 | Deep power-down bit of that write's data |
| link_sdata_in | input | 1 | Codec serial data input (asynchronous) |
| link_bitclk | input | 1 | Codec bit clock (asynchronous, may be stopped) |
| link_sync_out | output | 1 | Frame sync output to the codec |
| link_rst_n | output | 1 | Active-low codec reset output |
| irq | output | 1 | Wake interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so the bench checks a pulse output at the falling edge right after that write. It then counts the high or low samples one per clock to confirm the exact width. Inputs from the link pass through two synchronizer flops and an edge flop before a flag changes, so a wake or bit-clock result is due about three clocks after the input moves. The bench waits four to six clocks before it samples those flags. Counts below the threshold are checked as well: it checks one bit-clock edge short of the limit before it sends the last edge, so a ready flag that comes early is caught.

// File: rtl/lnk_pkg.sv
// Package: shared state encoding, register map and power-down decode constants
// for the AC-link reset and wake sequencer.
package lnk_pkg;

    // Reset sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_WARM    = 2'd1,
        SQ_COLD    = 2'd2,
        SQ_WAITCLK = 2'd3
    } seq_state_t;

    // Register addresses.
    localparam logic [1:0] ADR_MODE = 2'd0;
    localparam logic [1:0] ADR_MASK = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_CLEN = 2'd3;

    // Mode register bits.
    localparam int MODE_EN   = 0;
    localparam int MODE_WARM = 1;
    localparam int MODE_COLD = 2;

    // Status register bits.
    localparam int ST_READY  = 0;
    localparam int ST_WAKE   = 1;
    localparam int ST_BUSY   = 2;
    localparam int ST_ASLEEP = 3;

    // Codec power-down register address seen on the outgoing command slot.
    localparam logic [6:0] PD_REG_ADDR = 7'h26;

endpackage

// File: rtl/lnk_sync.sv
// Module: lnk_sync
// Two-flop synchronizer for WIDTH independent single-bit asynchronous inputs.
// Assumes each bit is a level that stays put for several clk periods, so no
// multi-bit coherence is needed. Synchronous active-low reset clears to 0.
module lnk_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // One two-flop chain for each input bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[g] <= 1'b0;
                stage2[g] <= 1'b0;
            end else begin
                stage1[g] <= async_in[g];
                stage2[g] <= stage1[g];
            end
        end
    end

    assign sync_out = stage2;

endmodule

// File: rtl/lnk_edge.sv
// Module: lnk_edge
// Rising-edge detector on a synchronized level. Gives a one-cycle pulse on
// each 0->1 transition. Assumes the input is already synchronous to clk.
module lnk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_d;

    // Keep the previous sample so a transition can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;

endmodule

// File: rtl/lnk_wake_det.sv
// Module: lnk_wake_det
// Wake flag. It is set by a rising edge of the synchronized codec data input,
// but only while the link is asleep. Software clears it by writing 1. A held
// high level does not set it again, because only edges count.
// Assumes sdata_rise is a single-cycle pulse in the clk domain.
module lnk_wake_det (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all,
    input  logic asleep,
    input  logic sdata_rise,
    input  logic clr_w1c,
    output logic wake_flag
);

    // Set on a wake edge while asleep. Cleared by W1C or by controller reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            wake_flag <= 1'b0;
        end else if (asleep && sdata_rise) begin
            wake_flag <= 1'b1;
        end else if (clr_w1c) begin
            wake_flag <= 1'b0;
        end
    end

    AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(asleep)); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_w1c) && !$past(sdata_rise)) |-> !wake_flag); // R3

endmodule

// File: rtl/lnk_rst_fsm.sv
// Module: lnk_rst_fsm
// Warm and cold reset sequencer. It times the pulse in system clocks, then
// counts bit-clock rising edges before it reports ready. Assumes
// start_warm/start_cold are already qualified by enable, and that
// bclk_rise is a synchronized single-cycle pulse.
module lnk_rst_fsm
    import lnk_pkg::*;
#(
    parameter int WARM_CYCLES = 50,
    parameter int BCLK_EDGES  = 4,
    parameter int CLEN_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_warm,
    input  logic              start_cold,
    input  logic [CLEN_W-1:0] cold_len,
    input  logic              sleep_enter,
    input  logic              bclk_rise,
    output logic              sync_out,
    output logic              codec_rst_n,
    output logic              busy,
    output logic              ready,
    output logic              seq_start
);

    localparam int WARM_W = $clog2(WARM_CYCLES + 1);
    localparam int CNT_W  = (WARM_W > CLEN_W) ? WARM_W : CLEN_W;
    localparam int EDGE_W = $clog2(BCLK_EDGES + 1);
    localparam logic [CNT_W-1:0]  WARM_LOAD = CNT_W'(WARM_CYCLES - 1);
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(BCLK_EDGES - 1);

    seq_state_t        state;
    logic [CNT_W-1:0]  pulse_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic [CNT_W-1:0]  cold_load;

    // Cold pulse length: a programmed 0 still gives one cycle.
    assign cold_load = (cold_len == '0) ? '0 : CNT_W'(cold_len - 1'b1);

    // A sequence starts only from idle; cold has priority over warm.
    assign seq_start = (state == SQ_IDLE) && (start_warm || start_cold);

    // State, pulse timer, edge counter and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state     <= SQ_IDLE;
            pulse_cnt <= '0;
            edge_cnt  <= '0;
            ready     <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_cold) begin
                        state     <= SQ_COLD;
                        pulse_cnt <= cold_load;
                        ready     <= 1'b0;
                    end else if (start_warm) begin
                        state     <= SQ_WARM;
                        pulse_cnt <= WARM_LOAD;
                        ready     <= 1'b0;
                    end else if (sleep_enter) begin
                        ready     <= 1'b0;
                    end
                end
                SQ_WARM, SQ_COLD: begin
                    if (pulse_cnt == '0) begin
                        state    <= SQ_WAITCLK;
                        edge_cnt <= '0;
                    end else begin
                        pulse_cnt <= pulse_cnt - 1'b1;
                    end
                end
                SQ_WAITCLK: begin
                    if (bclk_rise) begin
                        if (edge_cnt == EDGE_LAST) begin
                            state <= SQ_IDLE;
                            ready <= 1'b1;
                        end else begin
                            edge_cnt <= edge_cnt + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Outputs decoded from the registered state.
    assign sync_out    = (state == SQ_WARM);
    assign codec_rst_n = (state != SQ_COLD);
    assign busy        = (state != SQ_IDLE);

    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !busy); // R8

    AST_EDGE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt < EDGE_W'(BCLK_EDGES)); // R8

    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == SQ_WARM && state != SQ_IDLE) |-> state != SQ_COLD); // R9

    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy); // R10

endmodule

// File: rtl/aclink_pwr_seq.sv
// Module: aclink_pwr_seq
// Top of the AC-link reset and wake sequencer. It holds the software
// registers, tracks sleep entry from power-down register writes,
// synchronizes the link inputs, and joins the wake detector and the reset
// sequencer. Everything runs on the always-running system clock; the codec
// bit clock is only sampled.
module aclink_pwr_seq
    import lnk_pkg::*;
#(
    parameter int WARM_CYCLES = 50,
    parameter int BCLK_EDGES  = 4,
    parameter int CLEN_W      = 8,
    parameter int CLEN_RESET  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       pd_wr_valid,
    input  logic [6:0] pd_wr_addr,
    input  logic       pd_wr_pr4,
    input  logic       link_sdata_in,
    input  logic       link_bitclk,
    output logic       link_sync_out,
    output logic       link_rst_n,
    output logic       irq
);

    localparam int SYNC_W = 2;

    logic              ctl_en;
    logic              wake_ie;
    logic [CLEN_W-1:0] cold_len;
    logic              asleep;
    logic [SYNC_W-1:0] link_sync;
    logic              sdata_rise;
    logic              bclk_rise;
    logic              wake_flag;
    logic              busy;
    logic              ready;
    logic              seq_start;
    logic              wr_mode;
    logic              start_warm;
    logic              start_cold;
    logic              wake_w1c;
    logic              pd_hit;

    // Decode of register writes and requests.
    assign wr_mode    = reg_we && (reg_addr == ADR_MODE);
    assign start_warm = wr_mode && reg_wdata[MODE_WARM] && ctl_en && !busy;
    assign start_cold = wr_mode && reg_wdata[MODE_COLD] && ctl_en && !busy;
    assign wake_w1c   = reg_we && (reg_addr == ADR_STAT) && reg_wdata[ST_WAKE];
    assign pd_hit     = pd_wr_valid && (pd_wr_addr == PD_REG_ADDR) && pd_wr_pr4;

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            wake_ie  <= 1'b0;
            cold_len <= CLEN_W'(CLEN_RESET);
        end else if (reg_we) begin
            case (reg_addr)
                ADR_MODE: ctl_en   <= reg_wdata[MODE_EN];
                ADR_MASK: wake_ie  <= reg_wdata[0];
                ADR_CLEN: cold_len <= reg_wdata[CLEN_W-1:0];
                default:  ;
            endcase
        end
    end

    // Sleep tracking: set by a power-down write, cleared by any reset sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_en) begin
            asleep <= 1'b0;
        end else if (seq_start) begin
            asleep <= 1'b0;
        end else if (pd_hit) begin
            asleep <= 1'b1;
        end
    end

    // Bring both asynchronous link inputs into the system clock domain.
    lnk_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({link_bitclk, link_sdata_in}),
        .sync_out (link_sync)
    );

    lnk_edge u_sdata_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (link_sync[0]),
        .rise  (sdata_rise)
    );

    lnk_edge u_bclk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (link_sync[1]),
        .rise  (bclk_rise)
    );

    lnk_wake_det u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (!ctl_en),
        .asleep     (asleep),
        .sdata_rise (sdata_rise),
        .clr_w1c    (wake_w1c),
        .wake_flag  (wake_flag)
    );

    lnk_rst_fsm #(
        .WARM_CYCLES (WARM_CYCLES),
        .BCLK_EDGES  (BCLK_EDGES),
        .CLEN_W      (CLEN_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ctl_en),
        .start_warm  (start_warm),
        .start_cold  (start_cold),
        .cold_len    (cold_len),
        .sleep_enter (pd_hit),
        .bclk_rise   (bclk_rise),
        .sync_out    (link_sync_out),
        .codec_rst_n (link_rst_n),
        .busy        (busy),
        .ready       (ready),
        .seq_start   (seq_start)
    );

    assign irq = wake_flag && wake_ie;

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_MODE: reg_rdata[MODE_EN] = ctl_en;
            ADR_MASK: reg_rdata[0]       = wake_ie;
            ADR_STAT: reg_rdata[3:0]     = {asleep, busy, wake_flag, ready};
            ADR_CLEN: reg_rdata          = 8'(cold_len);
            default:  reg_rdata          = '0;
        endcase
    end

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wake_ie); // R4

    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sync_out || !link_rst_n) |-> (busy && !ready)); // R8

    AST_WARM_NO_CRST: assert property (@(posedge clk) disable iff (!rst_n)
        link_sync_out |-> link_rst_n); // R6

endmodule

// File: tb/sim_aclink_pwr_seq.sv
`timescale 1ns/1ps
module sim_aclink_pwr_seq;

    localparam int WARM = 50;
    localparam int EDGES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pd_wr_valid = 1'b0;
    logic [6:0] pd_wr_addr = 7'd0;
    logic       pd_wr_pr4 = 1'b0;
    logic       link_sdata_in = 1'b0;
    logic       link_bitclk = 1'b0;
    logic       link_sync_out;
    logic       link_rst_n;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    aclink_pwr_seq #(.WARM_CYCLES(WARM), .BCLK_EDGES(EDGES)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_wr_valid(pd_wr_valid),
        .pd_wr_addr(pd_wr_addr), .pd_wr_pr4(pd_wr_pr4), .link_sdata_in(link_sdata_in),
        .link_bitclk(link_bitclk), .link_sync_out(link_sync_out),
        .link_rst_n(link_rst_n), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pd_write(input logic [6:0] a, input logic p);
        @(negedge clk);
        pd_wr_valid = 1'b1; pd_wr_addr = a; pd_wr_pr4 = p;
        @(negedge clk);
        pd_wr_valid = 1'b0; pd_wr_pr4 = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bclk_edges(input int n);
        for (int i = 0; i < n; i++) begin
            link_bitclk = 1'b1; waitc(4);
            link_bitclk = 1'b0; waitc(4);
        end
    endtask

    // Status helper: returns {asleep,busy,wake,ready}.
    task automatic stat(output logic [3:0] s);
        logic [7:0] d;
        rd(2'd2, d);
        s = d[3:0];
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rst_n = 1'b0; waitc(4); rst_n = 1'b1; waitc(2);
        chk("R1 sync", link_sync_out, 0);
        chk("R1 rst_n", link_rst_n, 1);
        chk("R1 irq", irq, 0);
        rd(2'd0, d); chk("R1 mode", d, 0);
        rd(2'd2, d); chk("R1 status", d, 0);
    endtask

    task automatic t_sleep;
        logic [3:0] s;
        wr(2'd0, 8'h01);
        pd_write(7'h26, 1'b0); stat(s); chk("R5 pr4 clear ignored", s[3], 0);
        pd_write(7'h24, 1'b1); stat(s); chk("R5 other addr ignored", s[3], 0);
        pd_write(7'h26, 1'b1); stat(s); chk("R5 asleep set", s[3], 1);
    endtask

    task automatic t_wake;
        logic [3:0] s;
        // Edge while awake: enable, not asleep.
        wr(2'd0, 8'h00); wr(2'd0, 8'h01); wr(2'd1, 8'h01);
        link_sdata_in = 1'b1; waitc(6); stat(s);
        chk("R2 edge while awake", s[1], 0);
        link_sdata_in = 1'b0; waitc(6);
        pd_write(7'h26, 1'b1);
        link_sdata_in = 1'b1; waitc(5); stat(s);
        chk("R2 wake set", s[1], 1);
        chk("R4 irq with mask", irq, 1);
        wr(2'd2, 8'h02); waitc(6); stat(s);
        chk("R3 w1c clears, held high no retrigger", s[1], 0);
        chk("R4 irq drops", irq, 0);
        wr(2'd1, 8'h00);
        link_sdata_in = 1'b0; waitc(6);
        link_sdata_in = 1'b1; waitc(5); stat(s);
        chk("R2 wake set again", s[1], 1);
        chk("R4 irq masked", irq, 0);
        wr(2'd2, 8'h02); link_sdata_in = 1'b0; waitc(6);
        stat(s); chk("R3 wake cleared", s[1], 0);
    endtask

    task automatic t_warm;
        logic [3:0] s;
        int hi = 0;
        int rst_lo = 0;
        wr(2'd0, 8'h03);
        chk("R6 sync high after write", link_sync_out, 1);
        stat(s);
        chk("R8 busy during pulse", s[2], 1);
        chk("R5 start clears asleep", s[3], 0);
        // Cold request during pulse must be ignored.
        wr(2'd0, 8'h05);
        hi = 2;
        for (int i = 0; i < WARM + 20; i++) begin
            if (!link_rst_n) rst_lo++;
            if (link_sync_out) hi++;
            else break;
            @(negedge clk);
        end
        chk("R6 warm width", hi, WARM);
        chk("R9 cold ignored while busy", rst_lo, 0);
        bclk_edges(EDGES - 1); stat(s);
        chk("R8 busy before last edge", s[2], 1);
        chk("R8 not ready before last edge", s[0], 0);
        bclk_edges(1); stat(s);
        chk("R8 ready after edges", s[0], 1);
        chk("R8 busy clear after edges", s[2], 0);
    endtask

    task automatic t_cold(input logic [7:0] len, input int exp);
        logic [3:0] s;
        int lo = 0;
        int shi = 0;
        wr(2'd3, len);
        wr(2'd0, 8'h07); // warm and cold together: cold wins
        for (int i = 0; i < 300; i++) begin
            if (link_sync_out) shi++;
            if (!link_rst_n) lo++;
            else break;
            @(negedge clk);
        end
        chk("R7 cold width", lo, exp);
        chk("R9 cold wins, sync low", shi, 0);
        stat(s); chk("R8 not ready after pulse", s[0], 0);
        bclk_edges(EDGES); stat(s);
        chk("R8 ready after cold", s[0], 1);
    endtask

    task automatic t_disable;
        logic [3:0] s;
        wr(2'd3, 8'd40);
        wr(2'd0, 8'h05); waitc(3);
        chk("R7 cold active", link_rst_n, 0);
        wr(2'd0, 8'h00); waitc(1);
        chk("R10 rst released", link_rst_n, 1);
        stat(s); chk("R10 status cleared", s, 0);
        wr(2'd0, 8'h06); waitc(3);
        chk("R10 warm ignored disabled", link_sync_out, 0);
        chk("R10 cold ignored disabled", link_rst_n, 1);
    endtask

    initial begin
        t_reset();
        t_sleep();
        t_wake();
        pd_write(7'h26, 1'b1);
        t_warm();
        t_cold(8'd5, 5);
        t_cold(8'd0, 1);
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule